// File: doc/BRIEF.md
# DDR2 Burst Column Address Sequencer

This block produces the column address for each beat of a DDR2 read or write burst. A single-cycle start strobe loads a starting column, a burst length of four or eight, and a burst type (sequential or interleaved). Starting on the next clock, the block presents one column address per cycle until the burst is complete. It raises a valid flag throughout and marks the first and last beats.

Only the low column bits that form the burst field change during a burst. Those are bits 1:0 for a burst of four and bits 2:0 for a burst of eight. All higher bits stay at the loaded value.

In sequential mode with a burst of eight, the low two bits wrap within a group of four, and bit 2 flips for the second four beats. A strobe that arrives on the last beat chains the next burst with no gap. A strobe that arrives at any other point in a running burst is dropped and reported.

Top module: `burst_col_seq`

## Requirements
- R1: After reset, colValid, firstBeat, lastBeat and startDropped are all 0.
- R2: A start strobe sampled while no burst is running makes colValid and firstBeat 1 on the next cycle, with colOut equal to startCol.
- R3: With lenEight=0 (four beats) and modeIlv=0 (sequential), bits 1:0 of beat i equal startCol[1:0]+i modulo 4, and bit 2 keeps startCol[2].
- R4: With lenEight=1 (eight beats) and modeIlv=0, bits 1:0 of beat i equal startCol[1:0]+i modulo 4. Bit 2 equals startCol[2] for beats 0 to 3 and its inverse for beats 4 to 7. For example, start 5 gives 5,6,7,4,1,2,3,0.
- R5: With modeIlv=1 (interleaved), the burst field of beat i equals the start offset XOR i. For a burst of four, only bits 1:0 take part and bit 2 keeps startCol[2].
- R6: Column bits above bit 2 hold the loaded startCol value for every beat of the burst.
- R7: colValid stays 1 for exactly 4 or 8 consecutive cycles. firstBeat is 1 only on beat 0 and lastBeat is 1 only on the final beat. A start offset of 0 yields 0,1,...,N-1 in both modes.
- R8: A start strobe sampled while lastBeat is 1 begins the next burst on the following cycle, with no idle cycle between the two bursts.
- R9: A start strobe sampled during a burst but not on its last beat has no effect on the burst in progress. It makes startDropped 1 for exactly the next cycle.
- R10: startCol, lenEight and modeIlv are sampled only on an accepted start. Changing them during a burst has no effect on its addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| startStb | input | 1 | Single-cycle request to begin a burst |
| startCol | input | COL_W | Starting column address |
| lenEight | input | 1 | 1 = burst of eight, 0 = burst of four |
| modeIlv | input | 1 | 1 = interleaved order, 0 = sequential order |
| colOut | output | COL_W | Column address of the current beat |
| colValid | output | 1 | colOut holds a beat of a burst |
| firstBeat | output | 1 | Current beat is beat 0 |
| lastBeat | output | 1 | Current beat is the final beat |
| startDropped | output | 1 | One-cycle pulse: a start strobe was ignored |

## Verification
The bench builds the sequencer with COL_W set to 12 instead of the default 10. This widens the pass-through field enough that patterned upper bits can expose any leakage from the burst arithmetic into the held column bits.

At that width, the bench walks every start offset for both lengths and both orders. It also covers chaining on the last beat, and a dropped strobe issued with inverted column, length and mode.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;

  localparam int FIELD_W = 3;
  localparam int LOW_W   = 2;

  typedef struct packed {
    logic               load;
    logic [FIELD_W-1:0] beat;
  } seqCmd_t;

endpackage

// File: rtl/burst_col_ctrl.sv
module burst_col_ctrl
  import burst_col_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    startStb,
  input  logic    lenEight,
  output seqCmd_t cmd,
  output logic    colValid,
  output logic    firstBeat,
  output logic    lastBeat,
  output logic    startDropped
);

  logic               busy;
  logic               lenReg;
  logic [FIELD_W-1:0] beatCnt;
  logic [FIELD_W-1:0] finalIdx;
  logic               atLast;
  logic               accept;

  assign finalIdx = lenReg ? FIELD_W'(7) : FIELD_W'(3);
  assign atLast   = busy && (beatCnt == finalIdx);
  assign accept   = startStb && (!busy || atLast);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy         <= 1'b0;
      lenReg       <= 1'b0;
      beatCnt      <= '0;
      startDropped <= 1'b0;
    end else begin
      startDropped <= startStb && busy && !atLast;
      if (accept) begin
        busy    <= 1'b1;
        lenReg  <= lenEight;
        beatCnt <= '0;
      end else if (atLast) begin
        busy    <= 1'b0;
      end else if (busy) begin
        beatCnt <= beatCnt + 1'b1;
      end
    end
  end

  assign cmd.load  = accept;
  assign cmd.beat  = beatCnt;
  assign colValid  = busy;
  assign firstBeat = busy && (beatCnt == '0);
  assign lastBeat  = atLast;

endmodule

// File: rtl/burst_col_dp.sv
module burst_col_dp
  import burst_col_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  seqCmd_t          cmd,
  input  logic [COL_W-1:0] startCol,
  input  logic             modeIlv,
  output logic [COL_W-1:0] colOut
);

  localparam int UP_W = COL_W - FIELD_W;

  logic [COL_W-1:0]   baseCol;
  logic               ilvReg;
  logic [LOW_W-1:0]   lowBits;
  logic               halfBit;
  logic [FIELD_W-1:0] offs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      baseCol <= '0;
      ilvReg  <= 1'b0;
    end else if (cmd.load) begin
      baseCol <= startCol;
      ilvReg  <= modeIlv;
    end
  end

  assign offs = baseCol[FIELD_W-1:0];

  always_comb begin
    if (ilvReg) lowBits = offs[LOW_W-1:0] ^ cmd.beat[LOW_W-1:0];
    else        lowBits = offs[LOW_W-1:0] + cmd.beat[LOW_W-1:0];
    // beat index bit 2 is only ever set in an eight-beat burst
    halfBit = offs[2] ^ cmd.beat[2];
  end

  generate
    if (UP_W > 0) begin : g_upper
      assign colOut = {baseCol[COL_W-1:FIELD_W], halfBit, lowBits};
    end else begin : g_bare
      assign colOut = {halfBit, lowBits};
    end
  endgenerate

endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import burst_col_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             startStb,
  input  logic [COL_W-1:0] startCol,
  input  logic             lenEight,
  input  logic             modeIlv,
  output logic [COL_W-1:0] colOut,
  output logic             colValid,
  output logic             firstBeat,
  output logic             lastBeat,
  output logic             startDropped
);

  seqCmd_t cmd;

  burst_col_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .startStb(startStb), .lenEight(lenEight),
    .cmd(cmd), .colValid(colValid), .firstBeat(firstBeat),
    .lastBeat(lastBeat), .startDropped(startDropped)
  );

  burst_col_dp #(.COL_W(COL_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .startCol(startCol),
    .modeIlv(modeIlv), .colOut(colOut)
  );

endmodule

// File: rtl/burst_col_seq_chk.sv
module burst_col_seq_chk #(
  parameter int COL_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             startStb,
  input logic [COL_W-1:0] startCol,
  input logic [COL_W-1:0] colOut,
  input logic             colValid,
  input logic             firstBeat,
  input logic             lastBeat,
  input logic             startDropped
);

  a_r2_idle_start: assert property (@(posedge clk) disable iff (!rst_n)
    (startStb && !colValid) |=> (colValid && firstBeat && colOut == $past(startCol)));

  a_r6_upper_held: assert property (@(posedge clk) disable iff (!rst_n)
    (colValid && !lastBeat) |=> $stable(colOut[COL_W-1:3]));

  a_r7_last_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
    lastBeat |-> (colValid && !firstBeat));

  a_r7_first_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
    firstBeat |-> colValid);

  a_r8_chain: assert property (@(posedge clk) disable iff (!rst_n)
    (startStb && lastBeat) |=> (colValid && firstBeat));

  a_r9_drop_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (startStb && colValid && !lastBeat) |=> (startDropped && !firstBeat));

  a_r9_no_spurious_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !(startStb && colValid && !lastBeat) |=> !startDropped);

endmodule

bind burst_col_seq burst_col_seq_chk #(.COL_W(COL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .startStb(startStb), .startCol(startCol),
  .colOut(colOut), .colValid(colValid), .firstBeat(firstBeat),
  .lastBeat(lastBeat), .startDropped(startDropped)
);

// File: tb/burst_col_seq_tb.sv
`timescale 1ns/1ps
module burst_col_seq_tb;

  localparam int COL_W = 12;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             startStb = 1'b0;
  logic [COL_W-1:0] startCol = '0;
  logic             lenEight = 1'b0;
  logic             modeIlv = 1'b0;
  logic [COL_W-1:0] colOut;
  logic             colValid, firstBeat, lastBeat, startDropped;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  burst_col_seq #(.COL_W(COL_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .startStb(startStb), .startCol(startCol),
    .lenEight(lenEight), .modeIlv(modeIlv), .colOut(colOut),
    .colValid(colValid), .firstBeat(firstBeat), .lastBeat(lastBeat),
    .startDropped(startDropped)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [COL_W-1:0] expCol(input logic [COL_W-1:0] c,
                                               input logic l, input logic m, input int i);
    logic [2:0] s, b, f;
    s = c[2:0];
    b = 3'(i);
    if (m) begin
      f = l ? (s ^ b) : {s[2], s[1:0] ^ b[1:0]};
    end else begin
      f[1:0] = s[1:0] + b[1:0];
      f[2]   = (l && i >= 4) ? ~s[2] : s[2];
    end
    return {c[COL_W-1:3], f};
  endfunction

  task automatic driveStart(input logic [COL_W-1:0] c, input logic l, input logic m);
    startStb = 1'b1; startCol = c; lenEight = l; modeIlv = m;
  endtask

  // precondition: at a negedge with a start just driven
  task automatic expectBeats(input logic [COL_W-1:0] c, input logic l, input logic m,
                             input int poke, input bit chain,
                             input logic [COL_W-1:0] nc, input logic nl, input logic nm,
                             input string tag);
    int n;
    n = l ? 8 : 4;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      startStb = 1'b0;
      check(colValid === 1'b1, {tag, " R7 valid"}, colValid, 1);
      check(colOut === expCol(c, l, m, i), {tag, " addr"}, colOut, expCol(c, l, m, i));
      check(firstBeat === (i == 0), {tag, " R7 first"}, firstBeat, i == 0);
      check(lastBeat === (i == n - 1), {tag, " R7 last"}, lastBeat, i == n - 1);
      if (poke >= 0 && i == poke + 1)
        check(startDropped === 1'b1, {tag, " R9 dropped pulse"}, startDropped, 1);
      else if (i > 0)
        check(startDropped === 1'b0, {tag, " R9 no drop"}, startDropped, 0);
      if (i == poke) driveStart(~c, ~l, ~m);
      if (i == n - 1 && chain) driveStart(nc, nl, nm);
    end
  endtask

  task automatic expectIdle(input string tag);
    @(negedge clk);
    startStb = 1'b0;
    check(colValid === 1'b0, {tag, " R7 idle after burst"}, colValid, 0);
  endtask

  task automatic runOne(input logic [COL_W-1:0] c, input logic l, input logic m,
                        input string tag);
    driveStart(c, l, m);
    expectBeats(c, l, m, -1, 0, '0, 0, 0, tag);
    expectIdle(tag);
  endtask

  task automatic testReset;
    @(negedge clk);
    check(colValid === 0 && firstBeat === 0 && lastBeat === 0 && startDropped === 0,
          "R1 reset outputs", {colValid, firstBeat, lastBeat, startDropped}, 0);
  endtask

  task automatic testSeq4;
    for (int s = 0; s < 4; s++)
      runOne(12'hA54 | 12'(s), 0, 0, "R3 R2 seq4");
    runOne(12'h3F0, 0, 0, "R7 seq4 zero");
  endtask

  task automatic testSeq8;
    for (int s = 0; s < 8; s++)
      runOne(12'h5A8 | 12'(s), 1, 0, "R4 R6 seq8");
  endtask

  task automatic testIlv;
    for (int s = 0; s < 8; s++)
      runOne(12'hC38 | 12'(s), 1, 1, "R5 ilv8");
    for (int s = 0; s < 8; s++)
      runOne(12'h1E0 | 12'(s), 0, 1, "R5 ilv4");
  endtask

  task automatic testChain;
    driveStart(12'h7F5, 1, 0);
    expectBeats(12'h7F5, 1, 0, -1, 1, 12'h802, 0, 1, "R8 chain a");
    expectBeats(12'h802, 0, 1, -1, 1, 12'h00B, 1, 1, "R8 chain b");
    expectBeats(12'h00B, 1, 1, -1, 0, '0, 0, 0, "R8 chain c");
    expectIdle("R8 chain end");
  endtask

  task automatic testDrop;
    driveStart(12'h935, 1, 0);
    expectBeats(12'h935, 1, 0, 2, 0, '0, 0, 0, "R9 R10 drop8");
    expectIdle("R9 drop8 end");
    driveStart(12'h462, 0, 1);
    expectBeats(12'h462, 0, 1, 0, 0, '0, 0, 0, "R9 R10 drop4");
    expectIdle("R9 drop4 end");
  endtask

  initial begin
    #1;
    check(colValid === 0, "R1 reset valid", colValid, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    testReset();
    testSeq4();
    testSeq8();
    testIlv();
    testChain();
    testDrop();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule